// File: doc/BRIEF.md
# Host Interrupt Request Controller

This block collects single-cycle event strobes into sticky status bits and raises an active-low interrupt request toward a host whenever at least one of those bits is both set and enabled. The request stays low until the host reads the status register, clears the relevant enable bits, or resets the block. The host bus decoding and the logic that produces the events sit outside.

Reading the status register returns every latched bit and clears them all on the same clock edge. An event that strikes in the same cycle as the read is not lost. It is latched for the next read. While the request is pending, an incoming start command is blocked, so a new operation cannot begin before the host has handled the previous one.

The reset input asserts asynchronously and is released through a two-stage synchronizer.

Top module: `host_irq_ctrl`

## Requirements
- R1: `irq_n` is active low. It is 0 exactly when some bit `i` has both `status[i]` and `evt_en[i]` set. Otherwise it is 1.
- R2: A 1 on `evt_stb[i]` at a rising clock edge sets `status[i]` from that edge onward, whatever the value of `evt_en[i]`.
- R3: With `stat_rd` low, a set status bit stays set on every later edge.
- R4: When `stat_rd` is 1, `status` shows the bits being returned during that cycle. At that edge every bit is cleared unless its own strobe is also high.
- R5: An event strobe that arrives in the same cycle as `stat_rd` leaves its status bit set after the read.
- R6: Clearing the enable bits of all set status bits raises `irq_n` in the same cycle and leaves `status` unchanged. Setting one of those enable bits again lowers `irq_n`.
- R7: `start_out` equals `start_in` while `irq_n` is 1, and is 0 while `irq_n` is 0.
- R8: While `rst_n` is 0, `status` is all zeros and `irq_n` is 1, with no clock edge needed. Strobes present at the first two rising edges after `rst_n` rises are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_stb | input | N_EVT | One strobe per event source |
| evt_en | input | N_EVT | Interrupt enable for each event |
| stat_rd | input | 1 | Status register read strobe |
| start_in | input | 1 | Incoming start command |
| irq_n | output | 1 | Interrupt request, active low |
| status | output | N_EVT | Latched event bits |
| start_out | output | 1 | Start command gated by the pending request |

## Verification
The hardest case to reach from the ports is a strobe landing in exactly the cycle the host reads the status register. The stimulus table sets up such collisions several times: on bits that differ from the pending ones, on a disabled bit, and on all bits at once. Each time, the following row checks which bits survived.

A second hard case is the window just after reset release. A directed test holds every strobe high across the synchronizer stages and confirms that nothing is latched.

// File: rtl/host_irq_ctrl_pkg.sv
package host_irq_ctrl_pkg;
  typedef enum logic {
    IRQ_ASSERTED = 1'b0,
    IRQ_IDLE     = 1'b1
  } irq_level_e;

  localparam int unsigned RST_SYNC_STAGES = 2;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned N_EVT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_stb,
  input  logic             rd_clr,
  output logic [N_EVT-1:0] bits_q
);
  logic [N_EVT-1:0] bits_d;
  logic [N_EVT-1:0] bit_upd;

  for (genvar i = 0; i < N_EVT; i++) begin : g_bit
    always_comb begin
      bit_upd[i] = evt_stb[i] | rd_clr;
      if (evt_stb[i])  bits_d[i] = 1'b1;
      else if (rd_clr) bits_d[i] = 1'b0;
      else             bits_d[i] = bits_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          bits_q[i] <= 1'b0;
      else if (bit_upd[i]) bits_q[i] <= bits_d[i];
    end
  end
endmodule

// File: rtl/irq_req_merge.sv
module irq_req_merge
  import host_irq_ctrl_pkg::*;
#(
  parameter int unsigned N_EVT = 4
) (
  input  logic [N_EVT-1:0] bits,
  input  logic [N_EVT-1:0] enables,
  output irq_level_e       level
);
  logic [N_EVT-1:0] armed;
  logic             any_armed;

  always_comb begin
    armed     = bits & enables;
    any_armed = |armed;
    level     = any_armed ? IRQ_ASSERTED : IRQ_IDLE;
  end
endmodule

// File: rtl/host_irq_ctrl.sv
module host_irq_ctrl
  import host_irq_ctrl_pkg::*;
#(
  parameter int unsigned N_EVT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_stb,
  input  logic [N_EVT-1:0] evt_en,
  input  logic             stat_rd,
  input  logic             start_in,
  output logic             irq_n,
  output logic [N_EVT-1:0] status,
  output logic             start_out
);
  logic             rst_sync_n;
  logic [N_EVT-1:0] stat_bits;
  irq_level_e       req_level;

  irq_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_status_bank #(.N_EVT(N_EVT)) u_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .evt_stb (evt_stb),
    .rd_clr  (stat_rd),
    .bits_q  (stat_bits)
  );

  irq_req_merge #(.N_EVT(N_EVT)) u_merge (
    .bits    (stat_bits),
    .enables (evt_en),
    .level   (req_level)
  );

  always_comb begin
    status    = stat_bits;
    irq_n     = (req_level == IRQ_IDLE);
    start_out = start_in & (req_level == IRQ_IDLE);
  end
endmodule

// File: rtl/host_irq_ctrl_chk.sv
module host_irq_ctrl_chk #(
  parameter int unsigned N_EVT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_EVT-1:0] evt_stb,
  input logic [N_EVT-1:0] evt_en,
  input logic             stat_rd,
  input logic             start_in,
  input logic             irq_n,
  input logic [N_EVT-1:0] status,
  input logic             start_out
);
  // R2
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && ($past(evt_stb) != '0) |-> ((status & $past(evt_stb)) == $past(evt_stb)));

  // R3
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(stat_rd) |-> ((status & $past(status)) == $past(status)));

  // R4
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(stat_rd) |-> ((status & ~$past(evt_stb)) == '0));

  // R6
  irq_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & evt_en) == '0) |-> irq_n);

  // R1
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & evt_en) != '0) |-> !irq_n);

  // R7
  start_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> !start_out);

  // R7
  start_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n |-> (start_out == start_in));
endmodule

bind host_irq_ctrl host_irq_ctrl_chk #(.N_EVT(N_EVT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .evt_stb   (evt_stb),
  .evt_en    (evt_en),
  .stat_rd   (stat_rd),
  .start_in  (start_in),
  .irq_n     (irq_n),
  .status    (status),
  .start_out (start_out)
);

// File: tb/host_irq_ctrl_test.sv
module host_irq_ctrl_test;
  localparam int unsigned N = 4;
  localparam int unsigned NV = 16;

  // {evt[4], en[4], rd, start, exp_status[4], exp_irq_n, exp_start_out, req[4]}
  localparam logic [19:0] VEC [NV] = '{
    {4'h0, 4'hF, 1'b0, 1'b1, 4'h0, 1'b1, 1'b1, 4'd7}, // R7 pass through
    {4'h1, 4'hF, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 4'd1}, // R1 idle
    {4'h0, 4'hF, 1'b0, 1'b1, 4'h1, 1'b0, 1'b0, 4'd7}, // R7 blocked, R2 set
    {4'h4, 4'hF, 1'b0, 1'b0, 4'h1, 1'b0, 1'b0, 4'd3}, // R3
    {4'h0, 4'h0, 1'b0, 1'b1, 4'h5, 1'b1, 1'b1, 4'd6}, // R6 disable
    {4'h0, 4'hA, 1'b0, 1'b0, 4'h5, 1'b1, 1'b0, 4'd1}, // R1 no overlap
    {4'h0, 4'h4, 1'b0, 1'b1, 4'h5, 1'b0, 1'b0, 4'd6}, // R6 re-enable
    {4'h0, 4'hF, 1'b1, 1'b0, 4'h5, 1'b0, 1'b0, 4'd4}, // R4 read shows bits
    {4'h0, 4'hF, 1'b0, 1'b1, 4'h0, 1'b1, 1'b1, 4'd4}, // R4 cleared
    {4'h8, 4'h0, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 4'd2}, // R2 disabled event
    {4'h2, 4'hF, 1'b1, 1'b1, 4'h8, 1'b0, 1'b0, 4'd2}, // R2 latched
    {4'h0, 4'hF, 1'b0, 1'b1, 4'h2, 1'b0, 1'b0, 4'd5}, // R5 kept
    {4'h1, 4'h2, 1'b1, 1'b0, 4'h2, 1'b0, 1'b0, 4'd5}, // R5
    {4'h0, 4'h2, 1'b0, 1'b1, 4'h1, 1'b1, 1'b1, 4'd5}, // R5 disabled survivor
    {4'hF, 4'hF, 1'b1, 1'b0, 4'h1, 1'b0, 1'b0, 4'd5}, // R5 all collide
    {4'h0, 4'hF, 1'b0, 1'b0, 4'hF, 1'b0, 1'b0, 4'd5}  // R5 all kept
  };

  logic         clk;
  logic         rst_n;
  logic [N-1:0] evt_stb;
  logic [N-1:0] evt_en;
  logic         stat_rd;
  logic         start_in;
  logic         irq_n;
  logic [N-1:0] status;
  logic         start_out;

  int n_chk;
  int n_bad;
  bit done;

  host_irq_ctrl #(.N_EVT(N)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_stb   (evt_stb),
    .evt_en    (evt_en),
    .stat_rd   (stat_rd),
    .start_in  (start_in),
    .irq_n     (irq_n),
    .status    (status),
    .start_out (start_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [N-1:0] es,
                       input logic ei, input logic eo);
    n_chk++;
    if (status !== es || irq_n !== ei || start_out !== eo) begin
      n_bad++;
      $display("FAIL %s: status=%h irq_n=%b start_out=%b expected status=%h irq_n=%b start_out=%b",
               req, status, irq_n, start_out, es, ei, eo);
    end
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; evt_stb = '0; evt_en = '0; stat_rd = 1'b0; start_in = 1'b0;
    repeat (3) @(negedge clk);
    #1 check("R8 reset state", 4'h0, 1'b1, 1'b0);
    evt_en = 4'hF;
    start_in = 1'b1;
    #1 check("R8 reset holds irq idle", 4'h0, 1'b1, 1'b1);
    // R8: strobes held across the two synchronizer edges are ignored
    evt_stb = 4'hF;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    evt_stb = '0;
    #1 check("R8 release window", 4'h0, 1'b1, 1'b1);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      evt_stb  = VEC[k][19:16];
      evt_en   = VEC[k][15:12];
      stat_rd  = VEC[k][11];
      start_in = VEC[k][10];
      #1 check($sformatf("R%0d vector %0d", VEC[k][3:0], k),
               VEC[k][9:6], VEC[k][5], VEC[k][4]);
    end

    // R3: long hold without read
    @(negedge clk);
    evt_stb = '0; stat_rd = 1'b0; evt_en = 4'h0; start_in = 1'b1;
    repeat (20) @(negedge clk);
    #1 check("R3 long hold", 4'hF, 1'b1, 1'b1);

    // R8: asynchronous clear mid-cycle, no clock edge needed
    evt_en = 4'hF;
    #1 check("R1 pending before reset", 4'hF, 1'b0, 1'b0);
    rst_n = 1'b0;
    #0.5 check("R8 async clear", 4'h0, 1'b1, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    evt_stb = 4'h2;
    @(negedge clk); evt_stb = '0;
    #1 check("R2 after reset release", 4'h2, 1'b0, 1'b0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule